// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by an integer ratio that can be set in steps of one. A dual-modulus prescaler counts input cycles in groups of P or P+1. A program counter counts the prescaler's groups and ends each output period after N of them. A swallow counter keeps the prescaler in the P+1 mode for the first S groups of each period and then drops it to the P mode. One output period therefore lasts S·(P+1) + (N−S)·P = N·P + S input cycles. The output is a pulse that is high for exactly one input cycle, and it can feed a phase detector.

The block also exports the prescaler's mode-control level, so the swallow phase can be observed. N and S are sampled only at the boundary of an output period. A new channel setting therefore takes effect cleanly from the next period. An optional divide-by-two front stage, selected by a parameter, gates the whole chain on every other input cycle. This doubles the total ratio to 2·(N·P + S).

Top module: `pswal_divider`

## Requirements
- R1: With the front stage off, 1 ≤ N and 0 ≤ S ≤ N, consecutive rising edges of `div_pulse_o` are exactly N·P + S input cycles apart.
- R2: `div_pulse_o` is never high for two input cycles in a row.
- R3: In each output period, `mod_ctl_o` (1 = P+1 mode, 0 = P mode) is high for exactly the first S·(P+1) input cycles and low for the rest. With S = 0 it stays low for the whole period.
- R4: `mod_ctl_o` changes only on the clock edge that ends a prescaler group. While the swallow mode is active, the swallow count is nonzero.
- R5: `n_val_i` and `s_val_i` are sampled only on the edge that ends an output period. A change in the middle of a period leaves that period's length unchanged and applies to the following period.
- R6: With the front stage on (`PRE_DIV2` = 1), the output period is 2·(N·P + S) input cycles and `mod_ctl_o` is high for 2·S·(P+1) of them.
- R7: While `rst_ni` is low, `div_pulse_o` and `mod_ctl_o` are both low.
- R8: For a fixed N, raising S by one lengthens the output period by exactly one input cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| n_val_i | input | NW | Program count N (number of prescaler groups per period) |
| s_val_i | input | SW | Swallow count S (groups taken in P+1 mode), S ≤ N |
| div_pulse_o | output | 1 | One-cycle pulse once per output period |
| mod_ctl_o | output | 1 | Prescaler modulus control: 1 = divide by P+1, 0 = divide by P |

## Verification
The divider is swept over every legal (N, S) pair of a small configuration, from N = 1 upward and from S = 0 to S = N. Both the period length and the time spent in the P+1 mode are measured for each pair. The S = 0 and S = N ends tell apart a swallow latch that never engages from one that never releases. Comparing neighbouring S values shows the unit step. A period whose inputs change mid-way shows whether the setting is sampled only at the period boundary. A second instance with the front stage enabled repeats a shorter sweep to confirm the doubled ratio.

// File: rtl/pswal_pkg.sv
package pswal_pkg;
  typedef enum logic {
    MODE_BASE    = 1'b0,
    MODE_SWALLOW = 1'b1
  } pswal_mode_e;
endpackage

// File: rtl/pswal_prediv.sv
module pswal_prediv #(
  parameter bit PRE_DIV2 = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  output logic en
);
  generate
    if (PRE_DIV2) begin : g_div2
      logic ph_q, ph_d;
      assign ph_d = ~ph_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= 1'b0;
        else        ph_q <= ph_d;
      end
      assign en = ph_q;

      // R6: the enable alternates, halving the rate seen by the chain
      p_en_alternate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> !en);
    end else begin : g_pass
      logic unused_pass;
      assign unused_pass = clk ^ rst_n;
      assign en = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/pswal_prescaler.sv
module pswal_prescaler #(
  parameter int P = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic swallow,
  output logic pre_tc
);
  localparam int CW = $clog2(P + 1);

  logic [CW-1:0] cnt_q, cnt_d, term;

  assign term   = swallow ? CW'(P) : CW'(P - 1);
  assign pre_tc = en && (cnt_q == term);

  always_comb begin
    cnt_d = cnt_q;
    if (en) begin
      if (pre_tc) cnt_d = '0;
      else        cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: a group never runs past the P+1 terminal
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(P));
endmodule

// File: rtl/pswal_ctrl.sv
module pswal_ctrl
  import pswal_pkg::*;
#(
  parameter int NW = 4,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pre_tc,
  input  logic [NW-1:0] n_val,
  input  logic [SW-1:0] s_val,
  output logic          cyc_end,
  output pswal_mode_e   mode
);
  logic [NW-1:0] prog_q, prog_d;
  logic [SW-1:0] sw_q, sw_d;
  pswal_mode_e   mode_q, mode_d;

  assign cyc_end = pre_tc && (prog_q <= NW'(1));
  assign mode    = mode_q;

  always_comb begin
    prog_d = prog_q;
    sw_d   = sw_q;
    mode_d = mode_q;
    if (cyc_end) begin
      prog_d = n_val;
      sw_d   = s_val;
      mode_d = (s_val != '0) ? MODE_SWALLOW : MODE_BASE;
    end else if (pre_tc) begin
      prog_d = prog_q - NW'(1);
      if (sw_q != '0) begin
        sw_d = sw_q - SW'(1);
        if (sw_q == SW'(1)) mode_d = MODE_BASE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= NW'(1);
      sw_q   <= '0;
      mode_q <= MODE_BASE;
    end else begin
      prog_q <= prog_d;
      sw_q   <= sw_d;
      mode_q <= mode_d;
    end
  end

  // R4: the mode register only moves on the edge closing a prescaler group
  p_mode_on_tc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_tc |=> $stable(mode_q));
  // R4: swallow mode implies swallow groups remain
  p_swallow_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SWALLOW) |-> (sw_q != '0));
  // R3: the release to base mode follows a prescaler terminal event
  p_release_after_tc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_BASE && $past(mode_q) == MODE_SWALLOW) |-> $past(pre_tc));
endmodule

// File: rtl/pswal_divider.sv
module pswal_divider
  import pswal_pkg::*;
#(
  parameter int P        = 8,
  parameter int NW       = 4,
  parameter int SW       = 3,
  parameter bit PRE_DIV2 = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NW-1:0] n_val_i,
  input  logic [SW-1:0] s_val_i,
  output logic          div_pulse_o,
  output logic          mod_ctl_o
);
  logic        en;
  logic        pre_tc;
  logic        cyc_end;
  pswal_mode_e mode;

  pswal_prediv #(.PRE_DIV2(PRE_DIV2)) u_prediv (
    .clk(clk_i), .rst_n(rst_ni), .en(en)
  );

  pswal_prescaler #(.P(P)) u_pre (
    .clk(clk_i), .rst_n(rst_ni), .en(en),
    .swallow(mode == MODE_SWALLOW), .pre_tc(pre_tc)
  );

  pswal_ctrl #(.NW(NW), .SW(SW)) u_ctrl (
    .clk(clk_i), .rst_n(rst_ni), .pre_tc(pre_tc),
    .n_val(n_val_i), .s_val(s_val_i),
    .cyc_end(cyc_end), .mode(mode)
  );

  assign div_pulse_o = cyc_end;
  assign mod_ctl_o   = (mode == MODE_SWALLOW);

  // R2: output pulse lasts a single input cycle
  p_pulse_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_pulse_o |=> !div_pulse_o);
  // R7: outputs quiet while held in reset
  p_reset_quiet_r7: assert property (@(posedge clk_i)
    !rst_ni |-> (!div_pulse_o && !mod_ctl_o));
endmodule

// File: tb/pswal_divider_test.sv
module pswal_divider_test;
  localparam int P  = 8;
  localparam int NW = 4;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NW-1:0] n_val = NW'(1);
  logic [SW-1:0] s_val = '0;
  logic          pulse, modc, pulse2, modc2;
  int            checks = 0;
  int            errors = 0;
  int            cycles = 0;

  always #5 clk = ~clk;

  pswal_divider #(.P(P), .NW(NW), .SW(SW), .PRE_DIV2(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .n_val_i(n_val), .s_val_i(s_val),
    .div_pulse_o(pulse), .mod_ctl_o(modc)
  );

  pswal_divider #(.P(P), .NW(NW), .SW(SW), .PRE_DIV2(1'b1)) uut_d2 (
    .clk_i(clk), .rst_ni(rst_n), .n_val_i(n_val), .s_val_i(s_val),
    .div_pulse_o(pulse2), .mod_ctl_o(modc2)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic sel_pulse(input bit d2);
    return d2 ? pulse2 : pulse;
  endfunction

  function automatic logic sel_mod(input bit d2);
    return d2 ? modc2 : modc;
  endfunction

  task automatic sync_pulse(input bit d2);
    do @(negedge clk); while (!sel_pulse(d2));
  endtask

  // counts from just after a pulse up to and including the next pulse
  task automatic count_period(input bit d2, output int len, output int modhi);
    len = 0; modhi = 0;
    do begin
      @(negedge clk);
      len++;
      if (sel_mod(d2)) modhi++;
    end while (!sel_pulse(d2));
  endtask

  task automatic measure(input bit d2, input int n, input int s,
                         output int len, output int modhi);
    n_val = NW'(n);
    s_val = SW'(s);
    sync_pulse(d2);
    count_period(d2, len, modhi);
    @(negedge clk);
    check("R2 pulse width", int'(sel_pulse(d2)), 0);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 200000 cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin : stim
    int len, modhi, prev, l2, m2;
    repeat (3) @(negedge clk);
    check("R7 pulse in reset", int'(pulse), 0);
    check("R7 mod in reset", int'(modc), 0);
    check("R7 pulse in reset d2", int'(pulse2), 0);
    check("R7 mod in reset d2", int'(modc2), 0);
    rst_n = 1'b1;

    // R1, R3, R8: full sweep without front stage
    for (int n = 1; n < (1 << NW); n++) begin
      prev = 0;
      for (int s = 0; s <= n && s < (1 << SW); s++) begin
        measure(1'b0, n, s, len, modhi);
        check($sformatf("R1 period n=%0d s=%0d", n, s), len, n * P + s);
        check($sformatf("R3 swallow time n=%0d s=%0d", n, s), modhi, s * (P + 1));
        if (s > 0) check($sformatf("R8 step n=%0d s=%0d", n, s), len - prev, 1);
        prev = len;
      end
    end

    // R5: change setting in the middle of a period
    n_val = NW'(15);
    s_val = SW'(3);
    sync_pulse(1'b0);
    len = 0;
    repeat (5) begin
      @(negedge clk);
      len++;
    end
    n_val = NW'(2);
    s_val = SW'(1);
    do begin
      @(negedge clk);
      len++;
    end while (!pulse);
    check("R5 old setting held", len, 15 * P + 3);
    count_period(1'b0, l2, m2);
    check("R5 new setting applied", l2, 2 * P + 1);

    // R6: sweep with front stage
    for (int n = 1; n <= 6; n++) begin
      for (int s = 0; s <= n; s++) begin
        measure(1'b1, n, s, len, modhi);
        check($sformatf("R6 period n=%0d s=%0d", n, s), len, 2 * (n * P + s));
        check($sformatf("R6 swallow time n=%0d s=%0d", n, s), modhi, 2 * s * (P + 1));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule